// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers eight interrupt request lines, remembers each request from the moment its line rises, and picks one winner by fixed priority. Level 0 ranks highest. For the winner it drives an interrupt line to the processor and places a vector address on the I/O address lines. The vector is a programmable base plus twice the level number. The processor takes the interrupt with a one-cycle acknowledge pulse, which retires the request it was shown.

Software configures the block by programmed I/O writes to three registers:
- a per-level enable mask;
- a module-wide group enable bit, which gates all levels at once;
- the vector base.

A level takes part in arbitration only when its pending bit, its own enable and the group enable are all set. Up to eight controllers can sit on one bus in a daisy chain. A controller passes the grant downstream only when its upstream grant is present and it has nothing eligible of its own.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset no request is pending, the level enable mask, the group enable bit and the vector base are all zero, `irq_out` is low and `chain_out` follows `chain_in`.
- R2: A pending bit is set only on a low-to-high transition of its request line. A line held high after its request is retired does not raise it again.
- R3: Among eligible levels the lowest-numbered one wins.
- R4: While `irq_out` is high, `vec_addr` equals the base register plus two times the winning level, modulo 2^16. While `irq_out` is low, `vec_addr` is zero.
- R5: A level whose enable bit (cfg address 0, bit n for level n) is clear is not presented. Its request stays pending and is presented once the bit is set.
- R6: The group enable bit (cfg address 1, bit 0) is ANDed with every level enable. When it is clear nothing is presented, and pending requests survive.
- R7: An `ack` pulse while `irq_out` is high clears the pending bit of the level shown in that cycle, and only that bit.
- R8: An `ack` pulse while `irq_out` is low changes no pending bit.
- R9: `chain_out` is high exactly when `chain_in` is high and no level is eligible. With `chain_in` low, `irq_out` stays low.
- R10: If a new rising edge on a level coincides with the `ack` that retires that level, the level stays pending.
- R11: A write to cfg address 2 loads the vector base. A write to cfg address 3 changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 8 | Request lines, one per level, edge-detected |
| ack | input | 1 | Processor acknowledge pulse |
| cfg_wr | input | 1 | Programmed I/O write strobe |
| cfg_addr | input | 2 | Register select: 0 level enables, 1 group enable, 2 vector base, 3 unused |
| cfg_wdata | input | 16 | Write data |
| chain_in | input | 1 | Grant from the upstream controller (tie high on the first) |
| chain_out | output | 1 | Grant passed to the downstream controller |
| irq_out | output | 1 | Interrupt request to the processor |
| vec_addr | output | 16 | Vector address for the winning level, zero when idle |

## Verification
The hardest case to reach from the ports is a new request edge landing in the same cycle as the acknowledge that retires that level. The line must first pulse and fall so the level is pending and winning. The bench then raises it again together with `ack` on a single clock edge and checks that the level is still presented afterwards. Blocked states are also hard to see, because the pending register is not visible at the ports. These are disabled levels, a cleared group bit, and a low chain input, each possibly while `ack` is pulsed. The bench checks that such requests survive by lifting the block and reading the vector that appears.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;

  typedef enum logic [1:0] {
    SEL_LVL_EN = 2'd0,
    SEL_GRP_EN = 2'd1,
    SEL_BASE   = 2'd2,
    SEL_NONE   = 2'd3
  } cfg_sel_e;

  // vector spacing: each level owns two address words
  localparam int unsigned VEC_SHIFT = 1;

endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int unsigned NUM_LEVELS = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_LEVELS-1:0] req,
  input  logic [NUM_LEVELS-1:0] clr,
  output logic [NUM_LEVELS-1:0] pend
);

  logic [NUM_LEVELS-1:0] req_q, req_d;
  logic [NUM_LEVELS-1:0] pend_q, pend_d;
  logic [NUM_LEVELS-1:0] rise;

  always_comb begin
    rise   = req & ~req_q;
    req_d  = req;
    // a fresh edge outranks the clear of the same level
    pend_d = (pend_q & ~clr) | rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= '0;
      pend_q <= '0;
    end else begin
      req_q  <= req_d;
      pend_q <= pend_d;
    end
  end

  assign pend = pend_q;

  p_clr_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr));

  p_rise_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise) |=> ((pend_q & $past(rise)) == $past(rise)));

  p_clear_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr & ~rise)) |=> ((pend_q & $past(clr & ~rise)) == '0));

  p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((rise == '0) && (clr == '0)) |=> $stable(pend_q));

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int unsigned NUM_LEVELS = 8,
  localparam int unsigned LVL_W = (NUM_LEVELS > 1) ? $clog2(NUM_LEVELS) : 1
) (
  input  logic [NUM_LEVELS-1:0] elig,
  output logic [NUM_LEVELS-1:0] grant,
  output logic [LVL_W-1:0]      win_idx,
  output logic                  any
);

  // seen[i] is high when some level below i is eligible
  logic [NUM_LEVELS:0] seen;

  assign seen[0] = 1'b0;

  for (genvar i = 0; i < NUM_LEVELS; i++) begin : g_lvl
    assign grant[i]  = elig[i] & ~seen[i];
    assign seen[i+1] = seen[i] | elig[i];
  end

  assign any = seen[NUM_LEVELS];

  always_comb begin
    win_idx = '0;
    for (int i = NUM_LEVELS - 1; i >= 0; i--) begin
      if (elig[i]) win_idx = LVL_W'(i);
    end
  end

endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_vec_pkg::*;
#(
  parameter int unsigned NUM_LEVELS = 8,
  parameter int unsigned ADDR_W     = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr,
  input  logic [1:0]            sel,
  input  logic [ADDR_W-1:0]     wdata,
  output logic [NUM_LEVELS-1:0] lvl_en,
  output logic                  grp_en,
  output logic [ADDR_W-1:0]     base
);

  cfg_sel_e              sel_e;
  logic [NUM_LEVELS-1:0] lvl_en_q, lvl_en_d;
  logic                  grp_en_q, grp_en_d;
  logic [ADDR_W-1:0]     base_q, base_d;
  logic                  lvl_ce, grp_ce, base_ce;

  always_comb begin
    sel_e    = cfg_sel_e'(sel);
    lvl_ce   = wr && (sel_e == SEL_LVL_EN);
    grp_ce   = wr && (sel_e == SEL_GRP_EN);
    base_ce  = wr && (sel_e == SEL_BASE);
    lvl_en_d = wdata[NUM_LEVELS-1:0];
    grp_en_d = wdata[0];
    base_d   = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_en_q <= '0;
      grp_en_q <= 1'b0;
      base_q   <= '0;
    end else begin
      if (lvl_ce)  lvl_en_q <= lvl_en_d;
      if (grp_ce)  grp_en_q <= grp_en_d;
      if (base_ce) base_q   <= base_d;
    end
  end

  assign lvl_en = lvl_en_q;
  assign grp_en = grp_en_q;
  assign base   = base_q;

  p_unused_sel_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == 2'd3) |=> ($stable(lvl_en_q) && $stable(grp_en_q) && $stable(base_q)));

  p_base_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == 2'd2) |=> (base_q == $past(wdata)));

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_vec_pkg::*;
#(
  parameter int unsigned NUM_LEVELS = 8,
  parameter int unsigned ADDR_W     = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_LEVELS-1:0] irq_req,
  input  logic                  ack,
  input  logic                  cfg_wr,
  input  logic [1:0]            cfg_addr,
  input  logic [ADDR_W-1:0]     cfg_wdata,
  input  logic                  chain_in,
  output logic                  chain_out,
  output logic                  irq_out,
  output logic [ADDR_W-1:0]     vec_addr
);

  localparam int unsigned LVL_W = (NUM_LEVELS > 1) ? $clog2(NUM_LEVELS) : 1;

  logic [NUM_LEVELS-1:0] pend, lvl_en, elig, grant, clr;
  logic                  grp_en, any_elig, take;
  logic [ADDR_W-1:0]     base, offset;
  logic [LVL_W-1:0]      win_idx;

  irq_cfg_regs #(.NUM_LEVELS(NUM_LEVELS), .ADDR_W(ADDR_W)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (cfg_wr),
    .sel    (cfg_addr),
    .wdata  (cfg_wdata),
    .lvl_en (lvl_en),
    .grp_en (grp_en),
    .base   (base)
  );

  irq_pend_bank #(.NUM_LEVELS(NUM_LEVELS)) u_pend (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (irq_req),
    .clr   (clr),
    .pend  (pend)
  );

  irq_prio_pick #(.NUM_LEVELS(NUM_LEVELS)) u_pick (
    .elig    (elig),
    .grant   (grant),
    .win_idx (win_idx),
    .any     (any_elig)
  );

  always_comb begin
    elig      = pend & lvl_en & {NUM_LEVELS{grp_en}};
    irq_out   = chain_in & any_elig;
    chain_out = chain_in & ~any_elig;
    take      = ack & irq_out;
    clr       = take ? grant : '0;
    offset    = ADDR_W'(win_idx) << VEC_SHIFT;
    vec_addr  = irq_out ? (base + offset) : '0;
  end

  p_chain_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    chain_out |-> chain_in);

  p_chain_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_out && chain_out));

  p_group_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> grp_en);

  p_idle_vec_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_out |-> (vec_addr == '0));

  p_idle_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !irq_out) |-> (clr == '0));

endmodule

// File: tb/sim_irq_vector_ctrl.sv
`timescale 1ns/1ps
module sim_irq_vector_ctrl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  irq_req;
  logic        ack, cfg_wr, chain_in;
  logic [1:0]  cfg_addr;
  logic [15:0] cfg_wdata;
  logic        chain_out, irq_out;
  logic [15:0] vec_addr;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  logic [15:0] base_now;

  always #4 clk = ~clk;

  irq_vector_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .ack(ack),
    .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .chain_in(chain_in), .chain_out(chain_out), .irq_out(irq_out),
    .vec_addr(vec_addr)
  );

  // {lvl_en[19:12], req[11:4], expect_irq[3], expect_lvl[2:0]}
  localparam logic [19:0] TBL [8] = '{
    {8'hFF, 8'h01, 1'b1, 3'd0},
    {8'hFF, 8'h80, 1'b1, 3'd7},
    {8'hFF, 8'hA4, 1'b1, 3'd2},
    {8'hFF, 8'hF0, 1'b1, 3'd4},
    {8'hFE, 8'h03, 1'b1, 3'd1},
    {8'h0F, 8'hF0, 1'b0, 3'd0},
    {8'hF0, 8'h18, 1'b1, 3'd4},
    {8'hFF, 8'h00, 1'b0, 3'd0}
  };

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_vec(logic [15:0] b, int lvl);
    return b + 16'(2 * lvl);
  endfunction

  task automatic cfg(logic [1:0] a, logic [15:0] d);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    step();
    cfg_wr = 1'b0;
    if (a == 2'd2) base_now = d;
  endtask

  task automatic pulse(logic [7:0] p);
    irq_req = p;
    step();
    irq_req = 8'h00;
    step();
  endtask

  task automatic do_ack();
    ack = 1'b1;
    step();
    ack = 1'b0;
  endtask

  task automatic drain();
    cfg(2'd0, 16'h00FF);
    for (int k = 0; k < 9; k++) if (irq_out) do_ack();
  endtask

  task automatic expect_lvl(string tag, int lvl);
    check({tag, " irq"}, 32'(irq_out), 32'd1);
    check({tag, " vec"}, 32'(vec_addr), 32'(exp_vec(base_now, lvl)));
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    rst_n = 1'b0; irq_req = '0; ack = 1'b0; cfg_wr = 1'b0;
    cfg_addr = '0; cfg_wdata = '0; chain_in = 1'b1; base_now = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();

    // R1: reset state
    check("R1 irq_out", 32'(irq_out), 0);
    check("R1 vec_addr", 32'(vec_addr), 0);
    check("R1 chain_out", 32'(chain_out), 1);
    pulse(8'h01);   // enables are zero after reset
    check("R1 enables zero", 32'(irq_out), 0);
    cfg(2'd1, 16'h0001);
    cfg(2'd0, 16'h00FF);
    check("R1 base zero", 32'(vec_addr), 32'h0);
    drain();

    // R3 R4 R5: table of priority patterns
    cfg(2'd2, 16'h0400);
    foreach (TBL[i]) begin
      cfg(2'd0, {8'h00, TBL[i][19:12]});
      pulse(TBL[i][11:4]);
      check($sformatf("R3 irq row%0d", i), 32'(irq_out), 32'(TBL[i][3]));
      check($sformatf("R4 vec row%0d", i), 32'(vec_addr),
            TBL[i][3] ? 32'(exp_vec(base_now, int'(TBL[i][2:0]))) : 32'h0);
      drain();
    end

    // R5: disabled request survives and shows once enabled
    cfg(2'd0, 16'h00FB);
    pulse(8'h04);
    check("R5 masked", 32'(irq_out), 0);
    cfg(2'd0, 16'h00FF);
    expect_lvl("R5 unmasked", 2);
    drain();

    // R6: group enable gates everything
    cfg(2'd1, 16'h0000);
    pulse(8'h01);
    check("R6 group off irq", 32'(irq_out), 0);
    check("R6 group off chain", 32'(chain_out), 1);
    cfg(2'd1, 16'h0001);
    expect_lvl("R6 group on", 0);
    drain();

    // R7: ack retires only the shown level
    pulse(8'h05);
    expect_lvl("R7 first", 0);
    do_ack();
    expect_lvl("R7 second", 2);
    do_ack();
    check("R7 empty", 32'(irq_out), 0);

    // R8 R9: chain blocks, ack while idle is ignored
    pulse(8'h02);
    check("R9 chain_out low", 32'(chain_out), 0);
    chain_in = 1'b0;
    step();
    check("R9 blocked irq", 32'(irq_out), 0);
    check("R9 blocked chain", 32'(chain_out), 0);
    do_ack();
    chain_in = 1'b1;
    step();
    expect_lvl("R8 ack ignored", 1);
    drain();
    check("R9 chain passes", 32'(chain_out), 1);

    // R2: held line does not re-raise after retirement
    irq_req = 8'h08;
    step();
    expect_lvl("R2 raised", 3);
    do_ack();
    step();
    check("R2 held no repend", 32'(irq_out), 0);
    irq_req = 8'h00;
    step();
    pulse(8'h08);
    expect_lvl("R2 new edge", 3);
    drain();

    // R10: new edge coincides with ack of the same level
    pulse(8'h20);
    expect_lvl("R10 before", 5);
    ack = 1'b1; irq_req = 8'h20;
    step();
    ack = 1'b0; irq_req = 8'h00;
    step();
    expect_lvl("R10 kept", 5);
    drain();

    // R11: unused address ignored, base reload honoured
    pulse(8'h40);
    cfg(2'd3, 16'h0000);
    expect_lvl("R11 unused addr", 6);
    cfg(2'd2, 16'hFFFE);
    check("R11 base wrap", 32'(vec_addr), 32'h000A);
    drain();

    done = 1'b1;
    summary();
  end

endmodule